// File: doc/BRIEF.md
# Special-Function Register Overlay for a Two-Port Memory

This block sits between the two access ports of a 16-bit two-port memory and the memory array itself. When the active-low overlay enable `sfen_n` is held low, the two lowest word addresses stop being memory. Word 0 becomes a read-only view of two external status inputs. Word 1 becomes a five-bit output register that controls five on/off pull-down enables. Both ports reach these registers with their ordinary read and write cycles, and every other address passes through to the array unchanged.

For each port the block decodes the address, selects the read data (memory word, synchronized input pair or output register), and blocks the array's write enable whenever an overlaid word is addressed. A small mode machine has two states. In `MODE_MEMORY` both low words are ordinary storage and the outputs are off. In `MODE_REGISTER` the overlay is live. Transition `T_ENTER` goes from memory to register mode at a clock edge where `sfen_n` is low. Transition `T_LEAVE` goes from register to memory mode at an edge where `sfen_n` is high, and it clears the output register on that same edge.

Top module: `sfr_overlay`

## Requirements
- R1: While `rst_n` is low, the output register is all zero, `drv_out` is zero and the mode is `MODE_MEMORY`.
- R2: In register mode, a read at address 0 returns the synchronized inputs on bits 1:0, with bits 15:2 reading as zero.
- R3: Each `ext_in` bit passes through two flops. A change applied before clock edge k can be read at address 0 after edge k+1, and not after edge k.
- R4: In register mode, a port cycle with `cs_n`=0 and `we_n`=0 at address 1 loads `wdata[4:0]` into the output register at the clock edge. A 1 turns the matching `drv_out` bit on and a 0 turns it off. `wdata[15:5]` and writes to address 0 have no effect on the register.
- R5: In register mode, a read at address 1 returns the output register on bits 4:0, with bits 15:5 reading as zero.
- R6: Either port can write the output register. If both write it at the same edge, the left port's data is taken.
- R7: In register mode, `*_mem_we` stays low for addresses 0 and 1. For any other address it is high exactly when `cs_n`=0 and `we_n`=0, and the read data is the port's memory word.
- R8: In memory mode, addresses 0 and 1 read the port's memory word, `*_mem_we` follows `cs_n`=0 and `we_n`=0 for them, and `drv_out` is all zero.
- R9: Mode machine: `T_ENTER` happens at the first edge that samples `sfen_n` low. `T_LEAVE` happens at the first edge that samples it high and clears the output register, so after re-entry address 1 reads zero.
- R10: Writes to address 1 made in memory mode do not touch the output register.
- R11: A write cycle with `cs_n`=1 changes neither the output register nor `*_mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfen_n | input | 1 | Overlay enable, active low |
| lt_cs_n | input | 1 | Left port select, active low |
| lt_we_n | input | 1 | Left port write strobe, active low |
| lt_addr | input | ADDR_W | Left port word address |
| lt_wdata | input | DATA_W | Left port write data |
| lt_mem_rdata | input | DATA_W | Array read data for the left port |
| lt_rdata | output | DATA_W | Left port read data after steering |
| lt_mem_we | output | 1 | Array write enable for the left port, active high |
| rt_cs_n | input | 1 | Right port select, active low |
| rt_we_n | input | 1 | Right port write strobe, active low |
| rt_addr | input | ADDR_W | Right port word address |
| rt_wdata | input | DATA_W | Right port write data |
| rt_mem_rdata | input | DATA_W | Array read data for the right port |
| rt_rdata | output | DATA_W | Right port read data after steering |
| rt_mem_we | output | 1 | Array write enable for the right port, active high |
| ext_in | input | IN_W | External status inputs, asynchronous |
| drv_out | output | OUT_W | Pull-down enables, active high |

## Verification
The hardest case to reach from the ports is the clear performed by `T_LEAVE`. It leaves no trace in memory mode, because `drv_out` is zero there anyway. The stimulus therefore first loads a non-zero value, sends a memory-mode write to address 1 that must be ignored, and then re-enters register mode to read address 1 back as zero. Same-edge writes from both ports and the two-edge latency of the input synchronizer are reached by driving both ports together and reading address 0 at every negative edge after an input change.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    typedef enum logic {
        MODE_MEMORY   = 1'b0,
        MODE_REGISTER = 1'b1
    } sfr_mode_e;

    localparam int unsigned IN_WORD  = 0;
    localparam int unsigned OUT_WORD = 1;
    localparam int unsigned NPORTS   = 2;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else begin
                    if (s == 0) chain[s] <= d;
                    else        chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sfr_mode_ctrl.sv
module sfr_mode_ctrl
    import sfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sfen_n,
    output logic reg_mode,
    output logic clr_out
);
    sfr_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_MEMORY:   if (!sfen_n) state_d = MODE_REGISTER;
            MODE_REGISTER: if (sfen_n)  state_d = MODE_MEMORY;
            default:       state_d = MODE_MEMORY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_MEMORY;
        else        state_q <= state_d;
    end

    always_comb begin
        reg_mode = 1'b0;
        clr_out  = 1'b0;
        unique case (state_q)
            MODE_MEMORY: begin
                reg_mode = 1'b0;
                clr_out  = 1'b0;
            end
            MODE_REGISTER: begin
                reg_mode = 1'b1;
                clr_out  = sfen_n;
            end
            default: begin
                reg_mode = 1'b0;
                clr_out  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sfr_port_decode.sv
module sfr_port_decode
    import sfr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned IN_W   = 2,
    parameter int unsigned OUT_W  = 5
) (
    input  logic              reg_mode,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [IN_W-1:0]   in_val,
    input  logic [OUT_W-1:0]  out_val,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_we,
    output logic              out_wr
);
    logic hit_in, hit_out, wr_cycle;

    assign hit_in   = reg_mode && (addr == ADDR_W'(IN_WORD));
    assign hit_out  = reg_mode && (addr == ADDR_W'(OUT_WORD));
    assign wr_cycle = !cs_n && !we_n;

    always_comb begin
        if (hit_in)       rdata = {{(DATA_W-IN_W){1'b0}}, in_val};
        else if (hit_out) rdata = {{(DATA_W-OUT_W){1'b0}}, out_val};
        else              rdata = mem_rdata;
    end

    assign mem_we = wr_cycle && !hit_in && !hit_out;
    assign out_wr = wr_cycle && hit_out;
endmodule

// File: rtl/sfr_out_reg.sv
module sfr_out_reg #(
    parameter int unsigned OUT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_hi,
    input  logic [OUT_W-1:0] data_hi,
    input  logic             wr_lo,
    input  logic [OUT_W-1:0] data_lo,
    output logic [OUT_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (clr)    q <= '0;
        else if (wr_hi)  q <= data_hi;
        else if (wr_lo)  q <= data_lo;
    end
endmodule

// File: rtl/sfr_overlay.sv
module sfr_overlay
    import sfr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned IN_W        = 2,
    parameter int unsigned OUT_W       = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfen_n,
    input  logic              lt_cs_n,
    input  logic              lt_we_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [DATA_W-1:0] lt_wdata,
    input  logic [DATA_W-1:0] lt_mem_rdata,
    output logic [DATA_W-1:0] lt_rdata,
    output logic              lt_mem_we,
    input  logic              rt_cs_n,
    input  logic              rt_we_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    input  logic [DATA_W-1:0] rt_mem_rdata,
    output logic [DATA_W-1:0] rt_rdata,
    output logic              rt_mem_we,
    input  logic [IN_W-1:0]   ext_in,
    output logic [OUT_W-1:0]  drv_out
);
    logic              reg_mode, clr_out;
    logic [IN_W-1:0]   in_sync;
    logic [OUT_W-1:0]  out_q;

    logic              p_cs_n   [NPORTS];
    logic              p_we_n   [NPORTS];
    logic [ADDR_W-1:0] p_addr   [NPORTS];
    logic [DATA_W-1:0] p_wdata  [NPORTS];
    logic [DATA_W-1:0] p_mrdata [NPORTS];
    logic [DATA_W-1:0] p_rdata  [NPORTS];
    logic              p_mem_we [NPORTS];
    logic              p_out_wr [NPORTS];

    assign p_cs_n[0]   = lt_cs_n;
    assign p_we_n[0]   = lt_we_n;
    assign p_addr[0]   = lt_addr;
    assign p_wdata[0]  = lt_wdata;
    assign p_mrdata[0] = lt_mem_rdata;
    assign p_cs_n[1]   = rt_cs_n;
    assign p_we_n[1]   = rt_we_n;
    assign p_addr[1]   = rt_addr;
    assign p_wdata[1]  = rt_wdata;
    assign p_mrdata[1] = rt_mem_rdata;

    sfr_mode_ctrl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .sfen_n   (sfen_n),
        .reg_mode (reg_mode),
        .clr_out  (clr_out)
    );

    sfr_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_in),
        .q     (in_sync)
    );

    genvar p;
    generate
        for (p = 0; p < NPORTS; p++) begin : g_port
            sfr_port_decode #(
                .ADDR_W (ADDR_W),
                .DATA_W (DATA_W),
                .IN_W   (IN_W),
                .OUT_W  (OUT_W)
            ) u_dec (
                .reg_mode  (reg_mode),
                .cs_n      (p_cs_n[p]),
                .we_n      (p_we_n[p]),
                .addr      (p_addr[p]),
                .mem_rdata (p_mrdata[p]),
                .in_val    (in_sync),
                .out_val   (out_q),
                .rdata     (p_rdata[p]),
                .mem_we    (p_mem_we[p]),
                .out_wr    (p_out_wr[p])
            );
        end
    endgenerate

    sfr_out_reg #(.OUT_W(OUT_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_out),
        .wr_hi   (p_out_wr[0]),
        .data_hi (p_wdata[0][OUT_W-1:0]),
        .wr_lo   (p_out_wr[1]),
        .data_lo (p_wdata[1][OUT_W-1:0]),
        .q       (out_q)
    );

    assign lt_rdata  = p_rdata[0];
    assign rt_rdata  = p_rdata[1];
    assign lt_mem_we = p_mem_we[0];
    assign rt_mem_we = p_mem_we[1];
    assign drv_out   = reg_mode ? out_q : '0;
endmodule

// File: rtl/sfr_overlay_chk.sv
module sfr_overlay_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned IN_W   = 2,
    parameter int unsigned OUT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sfen_n,
    input logic              reg_mode,
    input logic              lt_cs_n,
    input logic              lt_we_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic [DATA_W-1:0] lt_wdata,
    input logic [DATA_W-1:0] lt_rdata,
    input logic              lt_mem_we,
    input logic              rt_cs_n,
    input logic              rt_we_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic [DATA_W-1:0] rt_wdata,
    input logic              rt_mem_we,
    input logic [OUT_W-1:0]  drv_out
);
    logic lt_wr1, rt_wr1, live;

    assign lt_wr1 = !lt_cs_n && !lt_we_n && (lt_addr == ADDR_W'(1));
    assign rt_wr1 = !rt_cs_n && !rt_we_n && (rt_addr == ADDR_W'(1));
    assign live   = reg_mode && !sfen_n;

    // R2: upper bits of the input word read as zero
    p_in_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode && lt_addr == ADDR_W'(0)) |-> (lt_rdata[DATA_W-1:IN_W] == '0));

    // R4: left write lands in the outputs at the next edge
    p_left_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && lt_wr1) |=> (drv_out == $past(lt_wdata[OUT_W-1:0])));

    // R4: register holds without a write
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !lt_wr1 && !rt_wr1) |=> $stable(drv_out));

    // R5: readback of the output word matches the driven outputs
    p_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode && lt_addr == ADDR_W'(1)) |-> (lt_rdata == DATA_W'(drv_out)));

    // R6: right port alone loads the register
    p_right_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && rt_wr1 && !lt_wr1) |=> (drv_out == $past(rt_wdata[OUT_W-1:0])));

    // R7: overlaid words never reach the array
    p_we_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode && (lt_addr < ADDR_W'(2))) |-> !lt_mem_we);

    p_we_block_rt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode && (rt_addr < ADDR_W'(2))) |-> !rt_mem_we);

    // R8: outputs off once memory mode is selected
    p_off_in_memory_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sfen_n |=> (drv_out == '0));

    // R11: no array write without select
    p_no_cs_no_we_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lt_cs_n |-> !lt_mem_we);
endmodule

bind sfr_overlay sfr_overlay_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IN_W   (IN_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfen_n    (sfen_n),
    .reg_mode  (reg_mode),
    .lt_cs_n   (lt_cs_n),
    .lt_we_n   (lt_we_n),
    .lt_addr   (lt_addr),
    .lt_wdata  (lt_wdata),
    .lt_rdata  (lt_rdata),
    .lt_mem_we (lt_mem_we),
    .rt_cs_n   (rt_cs_n),
    .rt_we_n   (rt_we_n),
    .rt_addr   (rt_addr),
    .rt_wdata  (rt_wdata),
    .rt_mem_we (rt_mem_we),
    .drv_out   (drv_out)
);

// File: tb/sfr_overlay_bench.sv
module sfr_overlay_bench;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;

    typedef enum int {S_LRD, S_RRD, S_DRV, S_LWE, S_RWE} sig_e;
    typedef struct {
        sig_e        sig;
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sfen_n = 1'b1;
    logic lt_cs_n = 1'b1, lt_we_n = 1'b1;
    logic rt_cs_n = 1'b1, rt_we_n = 1'b1;
    logic [ADDR_W-1:0] lt_addr = '0, rt_addr = '0;
    logic [DATA_W-1:0] lt_wdata = '0, rt_wdata = '0;
    logic [DATA_W-1:0] lt_mem_rdata, rt_mem_rdata, lt_rdata, rt_rdata;
    logic lt_mem_we, rt_mem_we;
    logic [1:0] ext_in = 2'b00;
    logic [4:0] drv_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    item_t sb_q[$];

    always #10 clk = ~clk;

    assign lt_mem_rdata = 16'hC000 | DATA_W'(lt_addr);
    assign rt_mem_rdata = 16'h5000 | DATA_W'(rt_addr);

    sfr_overlay u_sfr_overlay (
        .clk(clk), .rst_n(rst_n), .sfen_n(sfen_n),
        .lt_cs_n(lt_cs_n), .lt_we_n(lt_we_n), .lt_addr(lt_addr),
        .lt_wdata(lt_wdata), .lt_mem_rdata(lt_mem_rdata),
        .lt_rdata(lt_rdata), .lt_mem_we(lt_mem_we),
        .rt_cs_n(rt_cs_n), .rt_we_n(rt_we_n), .rt_addr(rt_addr),
        .rt_wdata(rt_wdata), .rt_mem_rdata(rt_mem_rdata),
        .rt_rdata(rt_rdata), .rt_mem_we(rt_mem_we),
        .ext_in(ext_in), .drv_out(drv_out)
    );

    task automatic expect_sig(sig_e s, logic [15:0] e, string tag);
        item_t it;
        it.sig = s; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic lt_cyc(logic cs, logic we, int a, logic [15:0] d);
        lt_cs_n = cs; lt_we_n = we; lt_addr = ADDR_W'(a); lt_wdata = d;
    endtask

    task automatic rt_cyc(logic cs, logic we, int a, logic [15:0] d);
        rt_cs_n = cs; rt_we_n = we; rt_addr = ADDR_W'(a); rt_wdata = d;
    endtask

    task automatic idle();
        lt_cyc(1'b1, 1'b1, 0, 16'h0);
        rt_cyc(1'b1, 1'b1, 0, 16'h0);
    endtask

    // monitor: compares every queued expectation 6 ns after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #6;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                case (it.sig)
                    S_LRD:   act = lt_rdata;
                    S_RRD:   act = rt_rdata;
                    S_DRV:   act = {11'b0, drv_out};
                    S_LWE:   act = {15'b0, lt_mem_we};
                    default: act = {15'b0, rt_mem_we};
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (2) @(negedge clk);
        expect_sig(S_DRV, 16'h0000, "R1 outputs off in reset");
        rst_n = 1'b1;

        // memory mode
        @(negedge clk);
        lt_cyc(1'b0, 1'b1, 1, 16'h0);
        rt_cyc(1'b0, 1'b1, 0, 16'h0);
        expect_sig(S_LRD, 16'hC001, "R8 addr1 is memory");
        expect_sig(S_RRD, 16'h5000, "R8 addr0 is memory");
        expect_sig(S_DRV, 16'h0000, "R1 outputs off after reset");

        @(negedge clk);
        lt_cyc(1'b0, 1'b0, 1, 16'h001F);
        rt_cyc(1'b1, 1'b1, 0, 16'h0);
        expect_sig(S_LWE, 16'h0001, "R8 memory write at addr1");

        @(negedge clk);
        lt_cyc(1'b0, 1'b1, 1, 16'h0);
        sfen_n = 1'b0;
        expect_sig(S_LRD, 16'hC001, "R9 mode not yet entered");
        expect_sig(S_DRV, 16'h0000, "R10 memory write ignored");

        @(negedge clk);
        rt_cyc(1'b0, 1'b1, 0, 16'h0);
        expect_sig(S_LRD, 16'h0000, "R10 register empty after entry");
        expect_sig(S_RRD, 16'h0000, "R2 inputs low");

        // synchronizer latency
        @(negedge clk);
        ext_in = 2'b10;
        expect_sig(S_RRD, 16'h0000, "R3 not yet visible");
        @(negedge clk);
        expect_sig(S_RRD, 16'h0000, "R3 one stage only");
        @(negedge clk);
        expect_sig(S_RRD, 16'h0002, "R3 R2 visible after two edges");

        // left write with junk upper bits
        @(negedge clk);
        lt_cyc(1'b0, 1'b0, 1, 16'hFFF5);
        rt_cyc(1'b1, 1'b1, 0, 16'h0);
        expect_sig(S_LWE, 16'h0000, "R7 addr1 write blocked");
        @(negedge clk);
        lt_cyc(1'b0, 1'b1, 1, 16'h0);
        expect_sig(S_DRV, 16'h0015, "R4 outputs loaded");
        expect_sig(S_LRD, 16'h0015, "R5 readback");

        // right write
        @(negedge clk);
        idle();
        rt_cyc(1'b0, 1'b0, 1, 16'h000A);
        expect_sig(S_RWE, 16'h0000, "R7 right addr1 blocked");
        @(negedge clk);
        rt_cyc(1'b0, 1'b1, 1, 16'h0);
        expect_sig(S_DRV, 16'h000A, "R6 right port writes");
        expect_sig(S_RRD, 16'h000A, "R5 right readback");

        // both write at the same edge
        @(negedge clk);
        lt_cyc(1'b0, 1'b0, 1, 16'h0003);
        rt_cyc(1'b0, 1'b0, 1, 16'h001C);
        @(negedge clk);
        idle();
        expect_sig(S_DRV, 16'h0003, "R6 left wins");

        // write without select
        @(negedge clk);
        lt_cyc(1'b1, 1'b0, 1, 16'h001F);
        expect_sig(S_LWE, 16'h0000, "R11 no select no write");
        @(negedge clk);
        idle();
        expect_sig(S_DRV, 16'h0003, "R11 register unchanged");

        // write to the input word
        @(negedge clk);
        rt_cyc(1'b0, 1'b0, 0, 16'hFFFF);
        expect_sig(S_RWE, 16'h0000, "R7 addr0 write blocked");
        @(negedge clk);
        idle();
        expect_sig(S_DRV, 16'h0003, "R4 addr0 write no effect");

        // ordinary address in register mode
        @(negedge clk);
        lt_cyc(1'b0, 1'b0, 2, 16'h1234);
        expect_sig(S_LWE, 16'h0001, "R7 addr2 writes memory");
        expect_sig(S_LRD, 16'hC002, "R7 addr2 reads memory");

        // new input pattern via right port
        @(negedge clk);
        idle();
        ext_in = 2'b01;
        @(negedge clk);
        @(negedge clk);
        rt_cyc(1'b0, 1'b1, 0, 16'h0);
        expect_sig(S_RRD, 16'h0001, "R2 input pattern 01");

        // leave register mode
        @(negedge clk);
        idle();
        sfen_n = 1'b1;
        expect_sig(S_DRV, 16'h0003, "R9 still in register mode");
        @(negedge clk);
        lt_cyc(1'b0, 1'b1, 1, 16'h0);
        rt_cyc(1'b0, 1'b0, 1, 16'h0007);
        expect_sig(S_DRV, 16'h0000, "R8 outputs off");
        expect_sig(S_LRD, 16'hC001, "R8 addr1 memory again");
        expect_sig(S_RWE, 16'h0001, "R8 addr1 memory write");

        @(negedge clk);
        idle();
        sfen_n = 1'b0;
        @(negedge clk);
        lt_cyc(1'b0, 1'b1, 1, 16'h0);
        expect_sig(S_LRD, 16'h0000, "R9 cleared on leave");
        expect_sig(S_DRV, 16'h0000, "R9 outputs stay off");

        @(negedge clk);
        #8;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule